// File: doc/BRIEF.md
# Reset Sequencer with Cause Tracking and Clock-Source Reload

This block gathers five reset requests: power-on, supply brown-out, external pin, watchdog timeout and software. From them it drives a system reset that stays asserted for a fixed power-on delay after the last request ends. While that delay runs, two more timers run beside it: an oscillator start-up wait and a PLL lock wait. Code execution is enabled only when the delay and both waits have ended. A clock-monitor start pulse follows the release of reset after its own delay.

Each cause sets its own sticky bit in a status vector, and software clears bits by writing zeros. On the way out of reset the block reloads a 3-bit oscillator selection. A cold reset (power-on or brown-out), or any reset while clock switching is off, loads the configured code. A warm reset (pin, watchdog or software) with switching on keeps the current code. The block drives two reset domains: one for ordinary registers, and one that only a power-on reset asserts. All delays are counted in the block's free-running reference clock.

Top module: `rstSequencer`

## Requirements
- R1: While `porReq` is high, the block holds `sysRstOut`, `ordRstOut` and `porDomRstOut` at 1, `runEn` and `monStart` at 0, and `rstStatus` at 5'b00001, asynchronously to the clock.
- R2: Status bit positions are fixed: 0 power-on, 1 brown-out, 2 pin, 3 watchdog, 4 software. Each cause sets its own bit, and the bit stays set. Bits of other causes are untouched, except that power-on leaves only bit 0 set.
- R3: A cycle with `stsWrEn` high clears each status bit whose `stsWrData` bit is 0 and leaves bits written with 1 unchanged. A request in the same cycle still sets its bit.
- R4: `supplyLow` causes a brown-out only while `lowVoltEn` is 1. With `lowVoltEn` at 0 it neither starts a reset nor sets a status bit.
- R5: `sysRstOut` is 1 while any request is active. After the last request drops it stays 1 for exactly POR_DLY more cycles, then stays 0 until the next request.
- R6: The oscillator and PLL timers run in parallel with the reset delay. `runEn` rises max(POR_DLY, OST_CNT, PLL_CNT) cycles after the last request drops.
- R7: `monStart` is a single-cycle pulse, POR_DLY+MON_DLY-1 cycles after the last request drops (the MON_DLY-th cycle after release).
- R8: With `clkSwEn` at 1, a power-on or brown-out reset loads `cfgOscSel` into `oscSel`, and a pin, watchdog or software reset loads `curOscSel`. The new value is visible in the first cycle after the requests drop.
- R9: With `clkSwEn` at 0, every reset type loads `cfgOscSel`.
- R10: `porDomRstOut` is asserted only by a power-on reset and falls together with `sysRstOut`. Later resets leave it at 0. `ordRstOut` follows `sysRstOut` for every reset.
- R11: A request arriving during the delay or after release restarts all timers from zero.
- R12: When a brown-out arrives together with a warm cause, the selection is the configured code and both status bits are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| porReq | input | 1 | Power-on request, asynchronous, active high |
| supplyLow | input | 1 | Supply-below-threshold flag |
| lowVoltEn | input | 1 | Enables brown-out detection |
| pinReq | input | 1 | External reset pin request |
| wdtReq | input | 1 | Watchdog timeout request |
| swReq | input | 1 | Software reset request |
| clkSwEn | input | 1 | Clock switching enabled |
| cfgOscSel | input | OSC_W | Configured oscillator code |
| curOscSel | input | OSC_W | Currently running oscillator code |
| stsWrEn | input | 1 | Status write strobe |
| stsWrData | input | 5 | Status write value (0 clears a bit) |
| sysRstOut | output | 1 | System reset |
| ordRstOut | output | 1 | Reset for ordinary registers |
| porDomRstOut | output | 1 | Reset for power-on-only registers |
| runEn | output | 1 | Code execution enable |
| monStart | output | 1 | Clock-monitor start pulse |
| oscSel | output | OSC_W | Active oscillator selection |
| rstStatus | output | 5 | Sticky reset-cause bits |

## Verification
Each reset cause is applied alone, once with clock switching on and once with it off. This separates the cold and warm reload paths from the switching-disabled override, and each status bit from its neighbours. The release, run-enable and monitor-pulse indices are measured from the drop of the request, with delays chosen so that a serial chain of timers gives different numbers than parallel ones. A request placed inside a running delay shows whether the timers restart. A brown-out paired with a watchdog reset, and a clearing write in the same cycle as a request, exercise the priority rules. A supply-low flag with detection disabled must leave both the reset and the status untouched.

// File: rtl/rstSeqPkg.sv
package rstSeqPkg;
  localparam int CAUSE_W = 5;
  localparam int C_POR = 0;
  localparam int C_BOR = 1;
  localparam int C_PIN = 2;
  localparam int C_WDT = 3;
  localparam int C_SW  = 4;
  localparam int N_TMR = 4;

  typedef enum logic [1:0] {ST_HOLD, ST_DELAY, ST_REL} seqState_t;

  typedef struct packed {
    logic holdCyc;    // in hold: clear timers, accumulate cold flag
    logic enterHold;  // a request interrupts delay or run
    logic loadOsc;    // last hold cycle: reload oscillator code
    logic cntRun;     // delay, oscillator and PLL timers advance
    logic monRun;     // monitor timer advances
  } seqStrobe_t;
endpackage

// File: rtl/rstSeqTimer.sv
module rstSeqTimer #(
  parameter int LIMIT = 8,
  parameter int CNT_W = 4,
  parameter bit EARLY = 1'b0
) (
  input  logic clk,
  input  logic arst,
  input  logic clr,
  input  logic run,
  output logic flag
);
  logic [CNT_W-1:0] cnt;
  logic atLast, atEnd;

  assign atLast = (cnt == CNT_W'(LIMIT - 1));
  assign atEnd  = (cnt == CNT_W'(LIMIT));

  always_ff @(posedge clk or posedge arst) begin
    if (arst)             cnt <= '0;
    else if (clr)         cnt <= '0;
    else if (run && !atEnd) cnt <= cnt + 1'b1;
  end

  generate
    if (EARLY) begin : g_early
      assign flag = atLast;
    end else begin : g_end
      assign flag = atEnd;
    end
  endgenerate
endmodule

// File: rtl/rstSeqCtrl.sv
module rstSeqCtrl
  import rstSeqPkg::*;
(
  input  logic       clk,
  input  logic       porReq,
  input  logic       anyReq,
  input  logic       delayLast,
  input  logic       oscDone,
  output seqStrobe_t strb,
  output logic       sysRst,
  output logic       runEn
);
  seqState_t state, stateNext;

  always_comb begin
    stateNext = state;
    case (state)
      ST_HOLD:  if (!anyReq) stateNext = ST_DELAY;
      ST_DELAY: if (anyReq) stateNext = ST_HOLD;
                else if (delayLast) stateNext = ST_REL;
      ST_REL:   if (anyReq) stateNext = ST_HOLD;
      default:  stateNext = ST_HOLD;
    endcase
  end

  always_ff @(posedge clk or posedge porReq) begin
    if (porReq) state <= ST_HOLD;
    else        state <= stateNext;
  end

  always_comb begin
    strb.holdCyc   = (state == ST_HOLD);
    strb.enterHold = (state != ST_HOLD) && anyReq;
    strb.loadOsc   = (state == ST_HOLD) && !anyReq;
    strb.cntRun    = (state != ST_HOLD);
    strb.monRun    = (state == ST_REL);
  end

  assign sysRst = (state != ST_REL);
  assign runEn  = (state == ST_REL) && oscDone;

  // R5: any request puts the system back into reset on the next cycle
  assert_req_forces_reset_R5: assert property (@(posedge clk) disable iff (porReq)
    anyReq |=> sysRst) else $error("request did not assert reset");

  // R5: once released, reset stays low while no request arrives
  assert_release_holds_R5: assert property (@(posedge clk) disable iff (porReq)
    (!sysRst && !anyReq) |=> !sysRst) else $error("reset reasserted without request");
endmodule

// File: rtl/rstSeqData.sv
module rstSeqData
  import rstSeqPkg::*;
#(
  parameter int POR_DLY = 64,
  parameter int OST_CNT = 128,
  parameter int PLL_CNT = 48,
  parameter int MON_DLY = 8,
  parameter int OSC_W   = 3
) (
  input  logic               clk,
  input  logic               porReq,
  input  seqStrobe_t         strb,
  input  logic               borReq,
  input  logic               pinReq,
  input  logic               wdtReq,
  input  logic               swReq,
  input  logic               clkSwEn,
  input  logic [OSC_W-1:0]   cfgOscSel,
  input  logic [OSC_W-1:0]   curOscSel,
  input  logic               stsWrEn,
  input  logic [CAUSE_W-1:0] stsWrData,
  output logic               delayLast,
  output logic               oscDone,
  output logic               monStart,
  output logic               porFlag,
  output logic [OSC_W-1:0]   oscSel,
  output logic [CAUSE_W-1:0] status
);
  localparam int M01   = (POR_DLY > OST_CNT) ? POR_DLY : OST_CNT;
  localparam int M23   = (PLL_CNT > MON_DLY) ? PLL_CNT : MON_DLY;
  localparam int MAXL  = (M01 > M23) ? M01 : M23;
  localparam int CNT_W = $clog2(MAXL + 1);
  localparam int       LIMS  [N_TMR] = '{POR_DLY, OST_CNT, PLL_CNT, MON_DLY};
  localparam bit       EARLY [N_TMR] = '{1'b1, 1'b0, 1'b0, 1'b1};

  logic [N_TMR-1:0] runVec, flagVec;
  logic             cold;
  logic [CAUSE_W-1:0] stsNext;

  assign runVec = {strb.monRun, strb.cntRun, strb.cntRun, strb.cntRun};

  generate
    for (genvar g = 0; g < N_TMR; g++) begin : g_tmr
      rstSeqTimer #(.LIMIT(LIMS[g]), .CNT_W(CNT_W), .EARLY(EARLY[g])) u_tmr (
        .clk (clk),
        .arst(porReq),
        .clr (strb.holdCyc),
        .run (runVec[g]),
        .flag(flagVec[g])
      );
    end
  endgenerate

  assign delayLast = flagVec[0];
  assign oscDone   = flagVec[1] & flagVec[2];
  assign monStart  = strb.monRun & flagVec[3];

  // cold marks a reset whose reload comes from configuration
  always_ff @(posedge clk or posedge porReq) begin
    if (porReq) begin
      cold    <= 1'b1;
      porFlag <= 1'b1;
    end else if (strb.enterHold) begin
      cold    <= borReq;
      porFlag <= 1'b0;
    end else if (strb.holdCyc) begin
      cold    <= cold | borReq;
    end
  end

  always_ff @(posedge clk or posedge porReq) begin
    if (porReq)            oscSel <= '0;
    else if (strb.loadOsc) oscSel <= (!clkSwEn || cold) ? cfgOscSel : curOscSel;
  end

  always_comb begin
    stsNext = status;
    if (stsWrEn) stsNext = stsNext & stsWrData;
    stsNext[C_BOR] = stsNext[C_BOR] | borReq;
    stsNext[C_PIN] = stsNext[C_PIN] | pinReq;
    stsNext[C_WDT] = stsNext[C_WDT] | wdtReq;
    stsNext[C_SW]  = stsNext[C_SW]  | swReq;
  end

  always_ff @(posedge clk or posedge porReq) begin
    if (porReq) status <= CAUSE_W'(1 << C_POR);
    else        status <= stsNext;
  end

  // R9: with switching off the reload always takes the configured code
  assert_osc_fixed_R9: assert property (@(posedge clk) disable iff (porReq)
    (strb.loadOsc && !clkSwEn) |=> (oscSel == $past(cfgOscSel)))
    else $error("switching disabled but configured code not loaded");

  // R2: a watchdog or software cause is recorded in the following cycle
  assert_cause_sticky_R2: assert property (@(posedge clk) disable iff (porReq)
    (wdtReq || swReq) |=> (status[C_WDT] || status[C_SW]))
    else $error("cause bit not recorded");
endmodule

// File: rtl/rstSequencer.sv
module rstSequencer
  import rstSeqPkg::*;
#(
  parameter int POR_DLY = 64,
  parameter int OST_CNT = 128,
  parameter int PLL_CNT = 48,
  parameter int MON_DLY = 8,
  parameter int OSC_W   = 3
) (
  input  logic               clk,
  input  logic               porReq,
  input  logic               supplyLow,
  input  logic               lowVoltEn,
  input  logic               pinReq,
  input  logic               wdtReq,
  input  logic               swReq,
  input  logic               clkSwEn,
  input  logic [OSC_W-1:0]   cfgOscSel,
  input  logic [OSC_W-1:0]   curOscSel,
  input  logic               stsWrEn,
  input  logic [CAUSE_W-1:0] stsWrData,
  output logic               sysRstOut,
  output logic               ordRstOut,
  output logic               porDomRstOut,
  output logic               runEn,
  output logic               monStart,
  output logic [OSC_W-1:0]   oscSel,
  output logic [CAUSE_W-1:0] rstStatus
);
  seqStrobe_t strb;
  logic borReq, anyReq, delayLast, oscDone, porFlag, sysRst;

  assign borReq = supplyLow & lowVoltEn;
  assign anyReq = borReq | pinReq | wdtReq | swReq;

  rstSeqCtrl u_ctrl (
    .clk      (clk),
    .porReq   (porReq),
    .anyReq   (anyReq),
    .delayLast(delayLast),
    .oscDone  (oscDone),
    .strb     (strb),
    .sysRst   (sysRst),
    .runEn    (runEn)
  );

  rstSeqData #(
    .POR_DLY(POR_DLY), .OST_CNT(OST_CNT), .PLL_CNT(PLL_CNT),
    .MON_DLY(MON_DLY), .OSC_W(OSC_W)
  ) u_data (
    .clk      (clk),
    .porReq   (porReq),
    .strb     (strb),
    .borReq   (borReq),
    .pinReq   (pinReq),
    .wdtReq   (wdtReq),
    .swReq    (swReq),
    .clkSwEn  (clkSwEn),
    .cfgOscSel(cfgOscSel),
    .curOscSel(curOscSel),
    .stsWrEn  (stsWrEn),
    .stsWrData(stsWrData),
    .delayLast(delayLast),
    .oscDone  (oscDone),
    .monStart (monStart),
    .porFlag  (porFlag),
    .oscSel   (oscSel),
    .status   (rstStatus)
  );

  assign sysRstOut    = sysRst;
  assign ordRstOut    = sysRst;
  assign porDomRstOut = porFlag & sysRst;

  // R10: the power-on-only domain never re-enters reset without power-on
  assert_pordom_only_por_R10: assert property (@(posedge clk) disable iff (porReq)
    !porDomRstOut |=> !porDomRstOut) else $error("power-on domain reset by warm cause");

  // R4: supply-low with detection off leaves a released system running
  assert_bor_gated_R4: assert property (@(posedge clk) disable iff (porReq)
    (supplyLow && !lowVoltEn && !pinReq && !wdtReq && !swReq && !sysRstOut) |=> !sysRstOut)
    else $error("brown-out acted while disabled");
endmodule

// File: tb/rstSequencer_tb.sv
module rstSequencer_tb;
  localparam int POR_DLY = 20;
  localparam int OST_CNT = 30;
  localparam int PLL_CNT = 12;
  localparam int MON_DLY = 5;
  localparam int WIN     = 40;

  typedef struct {
    int osc;
    int sts;
    int porDomCyc;
    int kind;   // 8: switching on, 9: switching off, 11: restart, 12: combined
  } item_t;

  logic clk = 1'b0;
  logic porReq = 1'b1, supplyLow = 1'b0, lowVoltEn = 1'b0;
  logic pinReq = 1'b0, wdtReq = 1'b0, swReq = 1'b0, clkSwEn = 1'b1;
  logic [2:0] cfgOscSel = 3'd5, curOscSel = 3'd2;
  logic stsWrEn = 1'b0;
  logic [4:0] stsWrData = 5'b0;
  logic sysRstOut, ordRstOut, porDomRstOut, runEn, monStart;
  logic [2:0] oscSel;
  logic [4:0] rstStatus;
  logic reqActive;

  int vecCnt = 0, errCnt = 0, pushCnt = 0, doneCnt = 0;
  bit finished = 1'b0;
  item_t q[$];

  always #4 clk = ~clk;   // 8 ns period, 125 MHz

  assign reqActive = porReq | pinReq | wdtReq | swReq | (supplyLow & lowVoltEn);

  rstSequencer #(.POR_DLY(POR_DLY), .OST_CNT(OST_CNT), .PLL_CNT(PLL_CNT),
                 .MON_DLY(MON_DLY), .OSC_W(3)) u_dut (
    .clk(clk), .porReq(porReq), .supplyLow(supplyLow), .lowVoltEn(lowVoltEn),
    .pinReq(pinReq), .wdtReq(wdtReq), .swReq(swReq), .clkSwEn(clkSwEn),
    .cfgOscSel(cfgOscSel), .curOscSel(curOscSel), .stsWrEn(stsWrEn),
    .stsWrData(stsWrData), .sysRstOut(sysRstOut), .ordRstOut(ordRstOut),
    .porDomRstOut(porDomRstOut), .runEn(runEn), .monStart(monStart),
    .oscSel(oscSel), .rstStatus(rstStatus)
  );

  task automatic check(string tag, int act, int exp);
    vecCnt++;
    if (act !== exp) begin
      errCnt++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  function automatic string oscTag(int kind);
    case (kind)
      9:       return "R9 osc reload with switching off";
      11:      return "R11 osc reload after restart";
      12:      return "R12 osc reload brown-out plus warm";
      default: return "R8 osc reload";
    endcase
  endfunction

  // push the expectation, then drop every request line (called at a negedge)
  task automatic pushDrop(int osc, int sts, int porDomCyc, int kind);
    item_t it;
    it.osc = osc; it.sts = sts; it.porDomCyc = porDomCyc; it.kind = kind;
    q.push_back(it);
    pushCnt++;
    porReq = 1'b0; pinReq = 1'b0; wdtReq = 1'b0; swReq = 1'b0; supplyLow = 1'b0;
    wait (doneCnt == pushCnt);
  endtask

  task automatic holdCheck(int cycles);
    repeat (cycles) @(negedge clk);
    check("R5 reset held during request", int'(sysRstOut), 1);
    check("R5 run blocked during request", int'(runEn), 0);
  endtask

  task automatic writeSts(logic [4:0] val);
    @(negedge clk); stsWrEn = 1'b1; stsWrData = val;
    @(negedge clk); stsWrEn = 1'b0;
  endtask

  // monitor: measures each release sequence from the cycle after the drop
  initial begin
    forever begin
      @(posedge clk); #2;
      if (q.size() > 0 && !reqActive) begin
        item_t it;
        int firstRel, firstRun, monIdx, monCount, pdCount, ordBad;
        it = q.pop_front();
        firstRel = -1; firstRun = -1; monIdx = -1; monCount = 0; pdCount = 0; ordBad = 0;
        for (int i = 0; i < WIN; i++) begin
          if (i > 0) begin @(posedge clk); #2; end
          if (i == 0) begin
            check(oscTag(it.kind), int'(oscSel), it.osc);
            check((it.kind == 12) ? "R12 status bits" : "R2 status bits", int'(rstStatus), it.sts);
          end
          if (firstRel < 0 && !sysRstOut) firstRel = i;
          if (firstRun < 0 && runEn) firstRun = i;
          if (monStart) begin monCount++; if (monIdx < 0) monIdx = i; end
          if (porDomRstOut) pdCount++;
          if (ordRstOut !== sysRstOut) ordBad++;
        end
        check((it.kind == 11) ? "R11 release after restart" : "R5 release index", firstRel, POR_DLY);
        check("R6 run enable index", firstRun, OST_CNT);
        check("R7 monitor pulse index", monIdx, POR_DLY + MON_DLY - 1);
        check("R7 monitor pulse width", monCount, 1);
        check("R10 power-on domain cycles", pdCount, it.porDomCyc);
        check("R10 ordinary domain follows reset", ordBad, 0);
        doneCnt++;
      end
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errCnt++;
      $display("FAIL watchdog (R1 to R12) actual=timeout expected=completion");
      $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
      $finish;
    end
  end

  initial begin
    // R1: power-on hold state
    repeat (3) @(negedge clk);
    check("R1 system reset", int'(sysRstOut), 1);
    check("R1 ordinary domain", int'(ordRstOut), 1);
    check("R1 power-on domain", int'(porDomRstOut), 1);
    check("R1 run enable", int'(runEn), 0);
    check("R1 monitor pulse", int'(monStart), 0);
    check("R1 status", int'(rstStatus), 5'b00001);
    pushDrop(5, 5'b00001, POR_DLY, 8);           // R8 cold: configured code

    // R8 warm pin reset keeps current code, R2 adds bit 2
    @(negedge clk); pinReq = 1'b1;
    holdCheck(3);
    pushDrop(2, 5'b00101, 0, 8);

    // R3 clearing writes
    writeSts(5'b11110);
    @(negedge clk); check("R3 zero clears bit", int'(rstStatus), 5'b00100);
    writeSts(5'b11111);
    @(negedge clk); check("R3 one keeps bit", int'(rstStatus), 5'b00100);
    writeSts(5'b00000);
    @(negedge clk); check("R3 clear all", int'(rstStatus), 0);

    // R4 supply-low ignored while detection disabled
    @(negedge clk); supplyLow = 1'b1;
    repeat (6) @(negedge clk);
    check("R4 no reset while disabled", int'(sysRstOut), 0);
    check("R4 run continues while disabled", int'(runEn), 1);
    check("R4 no status while disabled", int'(rstStatus), 0);

    // R4 enabled brown-out: cold reload of configured code
    cfgOscSel = 3'd6;
    lowVoltEn = 1'b1;
    holdCheck(3);
    pushDrop(6, 5'b00010, 0, 8);

    // R9 watchdog with switching off
    @(negedge clk); clkSwEn = 1'b0; wdtReq = 1'b1;
    holdCheck(2);
    pushDrop(6, 5'b01010, 0, 9);

    // R8 software reset with switching on and a new current code
    @(negedge clk); clkSwEn = 1'b1; curOscSel = 3'd3; swReq = 1'b1;
    holdCheck(2);
    pushDrop(3, 5'b11010, 0, 8);

    // R11 request inside a running delay restarts the timers
    writeSts(5'b00000);
    @(negedge clk); pinReq = 1'b1;
    repeat (3) @(negedge clk); pinReq = 1'b0;
    repeat (8) @(negedge clk);
    check("R11 still in reset mid-delay", int'(sysRstOut), 1);
    wdtReq = 1'b1;
    holdCheck(3);
    pushDrop(3, 5'b01100, 0, 11);

    // R12 brown-out together with watchdog
    writeSts(5'b00000);
    @(negedge clk); supplyLow = 1'b1; wdtReq = 1'b1;
    holdCheck(3);
    pushDrop(6, 5'b01010, 0, 12);

    // R3 request wins over a clearing write in the same cycle
    writeSts(5'b00000);
    @(negedge clk); pinReq = 1'b1; stsWrEn = 1'b1; stsWrData = 5'b00000;
    @(negedge clk); stsWrEn = 1'b0;
    check("R3 request beats clear", int'(rstStatus), 5'b00100);
    holdCheck(2);
    pushDrop(3, 5'b00100, 0, 8);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecCnt, errCnt);
    $finish;
  end
endmodule